// File: doc/BRIEF.md
# Serial GPIO Bank Interrupt Detector

This block watches the input half of a serial GPIO bank and turns changes or levels on those inputs into interrupt requests. The serial engine delivers one sample vector per frame covering every pin of the bank. Pins with an even index are inputs. Pins with an odd index are outputs, and this block ignores them.

Each input has its own enable bit, three trigger-type bits and a sticky status bit. The type bits select one of five triggers:
- falling edge
- rising edge
- both edges
- level low
- level high

Software reaches the configuration and status arrays through a small register port. Each access moves one 32-bit word, which holds one bit per input of the chosen bank. Status bits are cleared by writing ones to them. A single registered interrupt line is high while any input has both its status bit and its enable bit set.

Top module: `sirq_detector`

## Requirements
- R1: After reset, all enable bits are 0, all type bits are 0 (which selects falling edge), all status bits are 0, and `irq_o` is 0.
- R2: The register address is {kind[2:0], bank}. The kind codes are: 0 = enable, 1 = type0, 2 = type1, 3 = type2, 4 = status. A read returns its word on `rd_data_o`, with `rd_valid_o` high, in the cycle after `reg_rd_i`. Bit j of a word belongs to input b*WORD_W+j, which is sample bit 2*(b*WORD_W+j). A write to kinds 0 to 3 replaces the addressed word.
- R3: The trigger is decoded from the type bits as follows. If type1 is 1, the trigger is a level: level high when type0 is 1, level low when type0 is 0. If type1 is 0 and type2 is 1, the trigger is both edges. Otherwise the trigger is a rising edge when type0 is 1 and a falling edge when type0 is 0.
- R4: An edge is found by comparing a frame's sample with the sample of the previous frame. The first frame after reset produces no edge events.
- R5: A level trigger sets its status bit on every frame during which the level holds.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Status bits are recorded whether or not the input is enabled. `irq_o` is the OR of status AND enable over all inputs, registered, so it follows the status state by one cycle.
- R9: Odd-indexed sample bits never cause an event.
- R10: Reads of kinds 5 to 7, or of banks beyond the bank count, return 0, and writes to them change nothing. Word bits above the last input read as 0.
- R11: Status bits are set only in cycles where `samp_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid_i | input | 1 | Marks a new frame sample |
| samp_pins_i | input | PIN_CNT | Frame sample of all bank pins; only even bits are inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | {kind, bank} address |
| reg_wdata_i | input | WORD_W | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | WORD_W | Read data word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The main instance is built with PIN_CNT=128 and WORD_W=32. This gives 64 inputs in two full banks, so both values of the bank address bit and every trigger type can be driven, with frames and clears mixed randomly. A second instance is built with PIN_CNT=80, which gives 40 inputs. Its second bank is only partly filled, so the read-as-zero padding above the last input can be checked.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    K_EN  = 3'd0,
    K_T0  = 3'd1,
    K_T1  = 3'd2,
    K_T2  = 3'd3,
    K_ST  = 3'd4
  } reg_kind_e;

  localparam int KIND_W   = 3;
  localparam int CFG_KNDS = 4;
  localparam int RD_KNDS  = 5;
endpackage

// File: rtl/sirq_cfg_regs.sv
module sirq_cfg_regs #(
  parameter int IN_CNT = 64,
  parameter int WORD_W = 32,
  parameter int BANK_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [2:0]            kind_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [IN_CNT-1:0]     en_o,
  output logic [IN_CNT-1:0]     t0_o,
  output logic [IN_CNT-1:0]     t1_o,
  output logic [IN_CNT-1:0]     t2_o
);
  import sirq_pkg::*;

  logic [IN_CNT-1:0] cfg_q [CFG_KNDS];
  logic              hit;

  // Only kinds 0..3 are configuration words.
  assign hit = wr_i && (kind_i < 3'(CFG_KNDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CFG_KNDS; k++) cfg_q[k] <= '0;
    end else if (hit) begin
      for (int i = 0; i < IN_CNT; i++) begin
        if (bank_i == BANK_W'(i / WORD_W))
          cfg_q[kind_i[1:0]][i] <= wdata_i[i % WORD_W];
      end
    end
  end

  assign en_o = cfg_q[0];
  assign t0_o = cfg_q[1];
  assign t1_o = cfg_q[2];
  assign t2_o = cfg_q[3];

  // R1: the cycle reset is released, every config array reads back as zero
  assert_cfg_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_o == '0 && t0_o == '0 && t1_o == '0 && t2_o == '0));
endmodule

// File: rtl/sirq_edge_detect.sv
module sirq_edge_detect #(
  parameter int PIN_CNT = 128,
  parameter int IN_CNT  = PIN_CNT / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               samp_valid_i,
  input  logic [PIN_CNT-1:0] samp_pins_i,
  input  logic [IN_CNT-1:0]  t0_i,
  input  logic [IN_CNT-1:0]  t1_i,
  input  logic [IN_CNT-1:0]  t2_i,
  output logic [IN_CNT-1:0]  evt_o
);
  logic [IN_CNT-1:0] cur;
  logic [IN_CNT-1:0] prev_q;
  logic              primed_q;
  logic [IN_CNT-1:0] unused_odd;

  // Split the sample into input (even) and output (odd) pins.
  for (genvar i = 0; i < IN_CNT; i++) begin : g_split
    assign cur[i]        = samp_pins_i[2*i];
    assign unused_odd[i] = samp_pins_i[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (samp_valid_i) begin
      prev_q   <= cur;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < IN_CNT; i++) begin : g_det
    logic rise, fall, hit;
    assign rise = primed_q & cur[i] & ~prev_q[i];
    assign fall = primed_q & ~cur[i] & prev_q[i];
    always_comb begin
      if (t1_i[i])      hit = t0_i[i] ? cur[i] : ~cur[i];
      else if (t2_i[i]) hit = rise | fall;
      else              hit = t0_i[i] ? rise : fall;
    end
    assign evt_o[i] = samp_valid_i & hit;
  end
endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int IN_CNT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_CNT-1:0] evt_i,
  input  logic [IN_CNT-1:0] clr_i,
  input  logic [IN_CNT-1:0] en_i,
  output logic [IN_CNT-1:0] st_o,
  output logic              irq_o
);
  logic [IN_CNT-1:0] st_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr_i) | evt_i;
      irq_q <= |(st_q & en_i);
    end
  end

  assign st_o  = st_q;
  assign irq_o = irq_q;

  // R6: a clear without a competing event empties the bit next cycle
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~evt_i)) |=> ((st_q & $past(clr_i & ~evt_i)) == '0));

  // R7: an event colliding with a clear leaves the bit set
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & evt_i)) |=> ((st_q & $past(clr_i & evt_i)) == $past(clr_i & evt_i)));
endmodule

// File: rtl/sirq_detector.sv
module sirq_detector #(
  parameter int PIN_CNT = 128,
  parameter int WORD_W  = 32,
  localparam int IN_CNT   = PIN_CNT / 2,
  localparam int BANK_CNT = (IN_CNT + WORD_W - 1) / WORD_W,
  localparam int BANK_W   = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1,
  localparam int ADDR_W   = 3 + BANK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               samp_valid_i,
  input  logic [PIN_CNT-1:0] samp_pins_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic               rd_valid_o,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               irq_o
);
  import sirq_pkg::*;

  localparam int PAD_W = BANK_CNT * WORD_W;

  logic [2:0]        kind;
  logic [BANK_W-1:0] bank;
  logic              bank_ok;
  logic [IN_CNT-1:0] en, t0, t1, t2, st, evt, clr;

  assign kind    = reg_addr_i[ADDR_W-1 -: KIND_W];
  assign bank    = reg_addr_i[BANK_W-1:0];
  assign bank_ok = int'(bank) < BANK_CNT;

  sirq_cfg_regs #(.IN_CNT(IN_CNT), .WORD_W(WORD_W), .BANK_W(BANK_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .kind_i(kind), .bank_i(bank),
    .wdata_i(reg_wdata_i), .en_o(en), .t0_o(t0), .t1_o(t1), .t2_o(t2));

  sirq_edge_detect #(.PIN_CNT(PIN_CNT), .IN_CNT(IN_CNT)) u_det (
    .clk(clk), .rst(rst), .samp_valid_i(samp_valid_i), .samp_pins_i(samp_pins_i),
    .t0_i(t0), .t1_i(t1), .t2_i(t2), .evt_o(evt));

  // Write-one-to-clear mask for the addressed status word.
  for (genvar i = 0; i < IN_CNT; i++) begin : g_clr
    assign clr[i] = reg_wr_i && (kind == K_ST) && (bank == BANK_W'(i / WORD_W))
                    && reg_wdata_i[i % WORD_W];
  end

  sirq_status #(.IN_CNT(IN_CNT)) u_st (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_i(clr), .en_i(en),
    .st_o(st), .irq_o(irq_o));

  // Read path: arrays padded to whole words, padding tied low.
  logic [RD_KNDS-1:0][IN_CNT-1:0] src;
  logic [RD_KNDS-1:0][PAD_W-1:0]  rd_pad;
  assign src = {st, t2, t1, t0, en};

  for (genvar k = 0; k < RD_KNDS; k++) begin : g_pad_k
    for (genvar i = 0; i < PAD_W; i++) begin : g_pad_i
      if (i < IN_CNT) begin : g_real
        assign rd_pad[k][i] = src[k][i];
      end else begin : g_zero
        assign rd_pad[k][i] = 1'b0;
      end
    end
  end

  logic [WORD_W-1:0] rd_word;
  logic              rd_valid_q;
  logic [WORD_W-1:0] rd_data_q;

  always_comb begin
    rd_word = '0;
    if (kind < 3'(RD_KNDS) && bank_ok)
      rd_word = rd_pad[kind][int'(bank) * WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= reg_rd_i;
      if (reg_rd_i) rd_data_q <= rd_word;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R2: a read strobe yields valid data on the next cycle
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> rd_valid_o);

  // R8: a pending enabled status raises the line on the next cycle
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(st & en)) |=> irq_o);

  // R11: no status bit appears in a cycle without a frame
  assert_no_frame_no_set_R11: assert property (@(posedge clk) disable iff (rst)
    !samp_valid_i |=> ((st & ~$past(st)) == '0));
endmodule

// File: tb/sirq_detector_tb.sv
`timescale 1ns/1ps
module sirq_detector_tb_top;
  localparam int PINS = 128;
  localparam int NIN  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             sv;
  logic [PINS-1:0]  pins;
  logic             wr, rd;
  logic [3:0]       addr;
  logic [31:0]      wd;
  logic             rdv;
  logic [31:0]      rdd;
  logic             irq;

  sirq_detector #(.PIN_CNT(PINS), .WORD_W(32)) dut_i (
    .clk(clk), .rst(rst), .samp_valid_i(sv), .samp_pins_i(pins),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wd),
    .rd_valid_o(rdv), .rd_data_o(rdd), .irq_o(irq));

  // Small instance: 40 inputs, second bank partly filled.
  logic        s_wr, s_rd;
  logic [3:0]  s_addr;
  logic [31:0] s_wd;
  logic        s_rdv, s_irq;
  logic [31:0] s_rdd;
  sirq_detector #(.PIN_CNT(80), .WORD_W(32)) dut_small_i (
    .clk(clk), .rst(rst), .samp_valid_i(1'b0), .samp_pins_i('0),
    .reg_wr_i(s_wr), .reg_rd_i(s_rd), .reg_addr_i(s_addr), .reg_wdata_i(s_wd),
    .rd_valid_o(s_rdv), .rd_data_o(s_rdd), .irq_o(s_irq));

  int checks = 0;
  int fails  = 0;
  string tag = "R1 reset";

  // Reference model state
  logic [NIN-1:0] m_en, m_t0, m_t1, m_t2, m_st, m_prev;
  bit             m_primed;
  bit             e_irq, e_rdv;
  logic [31:0]    e_rd;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [2:0] k = a[3:1];
    int b = int'(a[0]);
    case (k)
      3'd0: return m_en[b*32 +: 32];
      3'd1: return m_t0[b*32 +: 32];
      3'd2: return m_t1[b*32 +: 32];
      3'd3: return m_t2[b*32 +: 32];
      3'd4: return m_st[b*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit trig(input int i, input logic [PINS-1:0] p);
    bit c = p[2*i];
    bit r = m_primed && c && !m_prev[i];
    bit f = m_primed && !c && m_prev[i];
    if (m_t1[i]) return m_t0[i] ? c : !c;          // R3 level
    if (m_t2[i]) return r || f;                     // R3 both
    return m_t0[i] ? r : f;                         // R3 single edge
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a, input logic [31:0] d,
                      input bit s, input logic [PINS-1:0] p);
    logic [NIN-1:0] evt, clr;
    @(negedge clk);
    check(irq == e_irq, "irq", 32'(irq), 32'(e_irq));
    check(rdv == e_rdv, "rd_valid", 32'(rdv), 32'(e_rdv));
    if (e_rdv) check(rdd == e_rd, "rd_data", rdd, e_rd);
    wr = w; rd = r; addr = a; wd = d; sv = s; pins = p;
    @(posedge clk);
    e_irq = |(m_st & m_en);
    e_rdv = r;
    if (r) e_rd = model_read(a);
    evt = '0; clr = '0;
    for (int i = 0; i < NIN; i++) begin
      if (s && trig(i, p)) evt[i] = 1'b1;
      if (w && a[3:1] == 3'd4 && int'(a[0]) == i / 32 && d[i % 32]) clr[i] = 1'b1;
    end
    m_st = (m_st & ~clr) | evt;
    if (w) begin
      for (int i = 0; i < NIN; i++) begin
        if (int'(a[0]) == i / 32) begin
          case (a[3:1])
            3'd0: m_en[i] = d[i % 32];
            3'd1: m_t0[i] = d[i % 32];
            3'd2: m_t1[i] = d[i % 32];
            3'd3: m_t2[i] = d[i % 32];
            default: ;
          endcase
        end
      end
    end
    if (s) begin
      for (int i = 0; i < NIN; i++) m_prev[i] = p[2*i];
      m_primed = 1'b1;
    end
  endtask

  logic [PINS-1:0] held = '0;
  task automatic wreg(input int k, input int b, input logic [31:0] d);
    step(1, 0, {3'(k), 1'(b)}, d, 0, held);
  endtask
  task automatic rreg(input int k, input int b);
    step(0, 1, {3'(k), 1'(b)}, 0, 0, held);
  endtask
  task automatic frame(input logic [PINS-1:0] p);
    held = p;
    step(0, 0, 0, 0, 1, p);
  endtask
  task automatic read_all();
    for (int k = 0; k < 5; k++) for (int b = 0; b < 2; b++) rreg(k, b);
  endtask

  function automatic logic [PINS-1:0] evens(input logic [NIN-1:0] v);
    logic [PINS-1:0] p = '0;
    for (int i = 0; i < NIN; i++) p[2*i] = v[i];
    return p;
  endfunction

  function automatic logic [PINS-1:0] rnd_pins();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    sv = 0; pins = '0; wr = 0; rd = 0; addr = '0; wd = '0;
    s_wr = 0; s_rd = 0; s_addr = '0; s_wd = '0;
    m_en = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0; m_st = '0; m_prev = '0; m_primed = 0;
    e_irq = 0; e_rdv = 0; e_rd = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    tag = "R1 reset"; read_all();

    // R4: first frame only primes edges; then falling edge on default type
    tag = "R4 first frame";
    wreg(0, 0, 32'hFFFF_FFFF);
    frame(evens('1)); rreg(4, 0); rreg(4, 1);
    tag = "R3 default falling";
    frame(evens('0)); rreg(4, 0); rreg(4, 1);
    tag = "R8 irq enable gating"; step(0, 0, 0, 0, 0, held); step(0, 0, 0, 0, 0, held);

    tag = "R6 write one clear";
    wreg(4, 0, 32'h0000_FFFF); rreg(4, 0);
    wreg(4, 0, 32'h0); rreg(4, 0);
    wreg(4, 0, 32'hFFFF_FFFF); wreg(4, 1, 32'hFFFF_FFFF); rreg(4, 0); rreg(4, 1);
    tag = "R8 irq drops"; step(0, 0, 0, 0, 0, held); step(0, 0, 0, 0, 0, held);

    // R7: rising event and clear in the same cycle
    tag = "R7 event beats clear";
    wreg(1, 0, 32'hFFFF_FFFF);
    step(1, 0, {3'd4, 1'b0}, 32'hFFFF_FFFF, 1, evens('1));
    held = evens('1);
    rreg(4, 0);
    wreg(4, 0, 32'hFFFF_FFFF); wreg(4, 1, 32'hFFFF_FFFF);

    // R5: level high on bank 1 sets every frame it holds
    tag = "R5 level high";
    wreg(2, 1, 32'hFFFF_FFFF); wreg(1, 1, 32'h0000_FFFF);
    frame(evens({32'h0F0F_F0F0, 32'h0}));
    rreg(4, 1); wreg(4, 1, 32'hFFFF_FFFF); rreg(4, 1);
    frame(evens({32'h0F0F_F0F0, 32'h0})); rreg(4, 1);
    wreg(4, 1, 32'hFFFF_FFFF);

    // R3: both edges
    tag = "R3 both edges";
    wreg(2, 0, 0); wreg(1, 0, 32'hFFFF_FFFF); wreg(3, 0, 32'hFFFF_FFFF);
    frame(evens({32'h0, 32'h0000_00FF})); rreg(4, 0); wreg(4, 0, 32'hFFFF_FFFF);
    frame(evens({32'h0, 32'h0000_0000})); rreg(4, 0); wreg(4, 0, 32'hFFFF_FFFF);

    // R9: odd bits toggle only
    tag = "R9 odd pins ignored";
    frame(held ^ {64{2'b10}}); frame(held ^ {64{2'b10}}); rreg(4, 0); rreg(4, 1);

    // R11: pins change with no frame strobe
    tag = "R11 no frame";
    step(0, 0, 0, 0, 0, ~held); step(0, 0, 0, 0, 0, ~held); rreg(4, 0); rreg(4, 1);

    // R10: unmapped kinds
    tag = "R10 unmapped";
    wreg(6, 0, 32'hFFFF_FFFF); wreg(5, 1, 32'hFFFF_FFFF);
    rreg(5, 0); rreg(7, 1); read_all();

    // R10: padding on the small instance
    @(negedge clk); s_wr = 1; s_addr = {3'd0, 1'b1}; s_wd = 32'hFFFF_FFFF;
    @(negedge clk); s_wr = 0; s_rd = 1;
    @(negedge clk); s_rd = 0;
    checks++;
    if (!(s_rdv && s_rdd == 32'h0000_00FF)) begin
      fails++;
      $display("FAIL R10 padding: actual %h expected %h", s_rdd, 32'h0000_00FF);
    end

    // Random mix covering R2, R3, R6 and R8
    tag = "R2 R3 random";
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 15));
      if (op < 3) step(0, 0, 0, 0, 1, rnd_pins());
      else if (op < 6) step(1, 0, a, $urandom, $urandom_range(0, 1), rnd_pins());
      else step(0, 1, a, 0, $urandom_range(0, 1), rnd_pins());
    end
    step(0, 0, 0, 0, 0, '0);
    step(0, 0, 0, 0, 0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule